// File: doc/BRIEF.md
# Circular-Buffer FIR Multiply-Accumulate Engine

This block is a sequential finite-impulse-response filter that spends one clock cycle on each tap. An incoming 16-bit sample is accepted over a valid/ready handshake and written into a circular delay line. The write overwrites the oldest stored entry, and no data is moved. The engine then walks a read pointer backwards through the delay line, from the newest sample to the oldest, with modulo wrap. On each tap cycle it reads one stored sample and one coefficient together. A 16x16 signed multiplier forms their product, and a saturating accumulator with guard bits (40 bits by default) adds it in.

When the last tap has been added, the accumulator is shifted left by one bit and its upper 16 bits are taken as the filter output. That value is clamped when it does not fit, registered, and announced with a one-cycle valid pulse. Coefficients are written through a simple address/data port while the engine is idle. Coefficient address k weights the sample that arrived k samples before the newest one. The tap count defaults to 128 and is a parameter.

Top module: `firMacTop`

## Requirements
- R1: Each output equals the sum over k = 0..TAPS-1 of coef[k] times x[n-k], where x[n] is the sample just accepted and coef[k] is the value last written at coefficient address k. The products are added in the order k = 0 first.
- R2: Reset clears the delay line and all coefficients to zero. Each accepted sample replaces the oldest stored sample, so a sample stops contributing after TAPS further samples.
- R3: The output is bits [2*DATA_W-2 : DATA_W-1] of the accumulator. This equals the accumulator shifted left by one with its high 16 bits kept, and it truncates toward minus infinity (for example, -49152 gives -2).
- R4: When the shifted accumulator lies outside the 16-bit range, the output is clamped to 32767 if it is positive and to -32768 if it is negative.
- R5: The accumulator starts from zero for every output sample, so no earlier sum carries over.
- R6: sampleReady is high only while the engine is idle. A sample is taken only on a clock edge where sampleValid and sampleReady are both high. While busy, sampleValid is ignored.
- R7: resultValid is a one-cycle pulse. It rises TAPS+1 clock edges after the accepting edge, and sampleReady is high again in that same cycle. resultData holds its value between pulses.
- R8: A coefficient write presented while the engine is busy is dropped. A write presented while idle takes effect for the next sample, including a sample accepted on the same edge.
- R9: After every tap, the accumulator saturates at the most positive and most negative ACC_W-bit values instead of wrapping.
- R10: After reset, sampleReady is 1, resultValid is 0 and resultData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A new input sample is offered |
| sampleData | input | DATA_W | Signed input sample |
| sampleReady | output | 1 | Engine is idle and can accept a sample |
| coefWrEn | input | 1 | Coefficient write strobe, used only while idle |
| coefAddr | input | clog2(TAPS) | Coefficient index (tap age) |
| coefData | input | DATA_W | Signed coefficient value |
| resultValid | output | 1 | One-cycle pulse marking a new output |
| resultData | output | DATA_W | Signed, scaled and clamped filter output |

## Verification
A result is due TAPS+1 clock edges after the accepting edge. The bench models this with a countdown that is loaded on the accepting edge. On every falling edge it compares sampleReady and resultValid with the model, and it compares resultData in the cycle where the model expects the pulse. Each directed case waits for the result pulse on a falling edge before it reads the output. A coefficient write during a busy cycle is placed on the cycle right after acceptance, so its effect can only appear on the following sample.

// File: rtl/firMacPkg.sv
package firMacPkg;

  // Strobes issued by the control block to the datapath each cycle
  typedef struct packed {
    logic writeSample;  // store the accepted sample at the write pointer
    logic clearAcc;     // start a fresh sum
    logic macEn;        // add one product this cycle
    logic emitResult;   // scale, clamp and register the output
    logic coefWrite;    // accept a coefficient write
  } firStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } firStateT;

endpackage

// File: rtl/firMacCtrl.sv
module firMacCtrl
  import firMacPkg::*;
#(
  parameter int TAPS = 128,
  localparam int AW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic          coefWrEn,
  output logic          sampleReady,
  output firStrobeT     strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [AW-1:0] coefIdx
);

  localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

  firStateT      state;
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [AW-1:0] tapIdx;
  logic [AW-1:0] remain;
  logic          isIdle;

  assign isIdle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wrPtr  <= '0;
      rdPtr  <= '0;
      tapIdx <= '0;
      remain <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (sampleValid) begin
            // newest sample sits where the write pointer points now
            rdPtr  <= wrPtr;
            wrPtr  <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
            tapIdx <= '0;
            remain <= LAST;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          rdPtr  <= (rdPtr == '0) ? LAST : rdPtr - 1'b1;
          tapIdx <= tapIdx + 1'b1;
          remain <= remain - 1'b1;
          if (remain == '0) state <= ST_FINISH;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.writeSample = isIdle && sampleValid;
    strobe.clearAcc    = isIdle && sampleValid;
    strobe.macEn       = (state == ST_RUN);
    strobe.emitResult  = (state == ST_FINISH);
    strobe.coefWrite   = isIdle && coefWrEn;
  end

  assign sampleReady = isIdle;
  assign wrAddr      = wrPtr;
  assign rdAddr      = rdPtr;
  assign coefIdx     = tapIdx;

endmodule

// File: rtl/firMacDatapath.sv
module firMacDatapath
  import firMacPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int TAPS   = 128,
  localparam int AW     = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int PROD_W = 2 * DATA_W,
  localparam int GUARD  = ACC_W - PROD_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  firStrobeT         strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [AW-1:0]     coefIdx,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [AW-1:0]     coefAddr,
  input  logic [DATA_W-1:0] coefData,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData
);

  logic signed [DATA_W-1:0] sampleMem [TAPS];
  logic signed [DATA_W-1:0] coefMem   [TAPS];
  logic signed [ACC_W-1:0]  acc;

  logic signed [DATA_W-1:0] tapSample;
  logic signed [DATA_W-1:0] tapCoef;
  logic signed [PROD_W-1:0] product;
  logic signed [ACC_W:0]    wideSum;
  logic signed [ACC_W-1:0]  accNext;
  logic [GUARD-1:0]         upperBits;
  logic                     fitsOut;
  logic [DATA_W-1:0]        scaled;

  localparam logic [ACC_W-1:0]  ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] OUT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] OUT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  // Delay line: written at the write pointer, never shifted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) sampleMem[i] <= '0;
    end else if (strobe.writeSample) begin
      sampleMem[wrAddr] <= sampleData;
    end
  end

  // Coefficient store
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) coefMem[i] <= '0;
    end else if (strobe.coefWrite && (int'(coefAddr) < TAPS)) begin
      coefMem[coefAddr] <= coefData;
    end
  end

  // One tap: both stores read in the same cycle, then multiply-add
  always_comb begin
    tapSample = sampleMem[rdAddr];
    tapCoef   = coefMem[coefIdx];
    product   = tapSample * tapCoef;
    wideSum   = {acc[ACC_W-1], acc} +
                {{(ACC_W + 1 - PROD_W){product[PROD_W-1]}}, product};
    if (wideSum[ACC_W] != wideSum[ACC_W-1])
      accNext = wideSum[ACC_W] ? ACC_MIN : ACC_MAX;
    else
      accNext = wideSum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               acc <= '0;
    else if (strobe.clearAcc) acc <= '0;
    else if (strobe.macEn)    acc <= accNext;
  end

  // Output scaling: shift left one, keep the high half, clamp
  always_comb begin
    upperBits = acc[ACC_W-1 -: GUARD];
    fitsOut   = (&upperBits) || !(|upperBits);
    if (fitsOut)
      scaled = acc[PROD_W-2 : DATA_W-1];
    else
      scaled = acc[ACC_W-1] ? OUT_MIN : OUT_MAX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultData  <= '0;
    end else begin
      resultValid <= strobe.emitResult;
      if (strobe.emitResult) resultData <= scaled;
    end
  end

endmodule

// File: rtl/firMacTop.sv
module firMacTop
  import firMacPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int TAPS   = 128,
  localparam int AW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic              sampleReady,
  input  logic              coefWrEn,
  input  logic [AW-1:0]     coefAddr,
  input  logic [DATA_W-1:0] coefData,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData
);

  firStrobeT     strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;
  logic [AW-1:0] coefIdx;

  firMacCtrl #(.TAPS(TAPS)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .coefWrEn   (coefWrEn),
    .sampleReady(sampleReady),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .coefIdx    (coefIdx)
  );

  firMacDatapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .TAPS(TAPS)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .coefIdx    (coefIdx),
    .sampleData (sampleData),
    .coefAddr   (coefAddr),
    .coefData   (coefData),
    .resultValid(resultValid),
    .resultData (resultData)
  );

endmodule

// File: rtl/firMacChecker.sv
module firMacChecker #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              sampleReady,
  input logic              resultValid,
  input logic [DATA_W-1:0] resultData,
  input logic              coefWrite
);

  // Counts edges since acceptance, the accepting edge counting as one
  int unsigned sinceAccept;

  always_ff @(posedge clk) begin
    if (!rstN)                          sinceAccept <= 0;
    else if (sampleValid && sampleReady) sinceAccept <= 1;
    else if (resultValid)                sinceAccept <= 0;
    else if (sinceAccept != 0)           sinceAccept <= sinceAccept + 1;
  end

  // R6: an accepted sample makes the engine busy on the next cycle
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleReady) |=> !sampleReady);

  // R6: no readiness while a computation is in flight
  a_r6_no_ready_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    (sinceAccept != 0 && !resultValid) |-> !sampleReady);

  // R7: result pulse lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R7: pulse arrives TAPS+1 edges after the accepting edge
  a_r7_latency: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (sinceAccept == TAPS + 2));

  // R7: output held between pulses
  a_r7_data_held: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(resultData));

  // R8: coefficient writes are taken only while idle
  a_r8_coef_idle_only: assert property (@(posedge clk) disable iff (!rstN)
    coefWrite |-> sampleReady);

endmodule

bind firMacTop firMacChecker #(.DATA_W(DATA_W), .TAPS(TAPS)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .sampleReady(sampleReady),
  .resultValid(resultValid),
  .resultData (resultData),
  .coefWrite  (strobe.coefWrite)
);

// File: tb/sim_firMacTop.sv
`timescale 1ns/1ps
module sim_firMacTop;

  localparam int TAPS  = 8;
  localparam int DW    = 16;
  localparam int ACCW  = 32;
  localparam int AW    = $clog2(TAPS);
  localparam longint ACC_HI = (64'sd1 <<< (ACCW - 1)) - 1;
  localparam longint ACC_LO = -(64'sd1 <<< (ACCW - 1));

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [DW-1:0] sampleData = '0;
  logic          sampleReady;
  logic          coefWrEn = 1'b0;
  logic [AW-1:0] coefAddr = '0;
  logic [DW-1:0] coefData = '0;
  logic          resultValid;
  logic [DW-1:0] resultData;

  int passCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  firMacTop #(.DATA_W(DW), .ACC_W(ACCW), .TAPS(TAPS)) u0 (
    .clk(clk), .rstN(rstN),
    .sampleValid(sampleValid), .sampleData(sampleData), .sampleReady(sampleReady),
    .coefWrEn(coefWrEn), .coefAddr(coefAddr), .coefData(coefData),
    .resultValid(resultValid), .resultData(resultData)
  );

  // ---------------- behavioural reference model ----------------
  int  hist[$];
  int  coefM[TAPS];
  int  busyCnt;
  bit  expValid;
  int  expData;

  function automatic int computeOut();
    longint a = 0;
    longint sh;
    for (int k = 0; k < TAPS; k++) begin
      a = a + longint'(coefM[k]) * longint'(hist[k]);
      if (a > ACC_HI) a = ACC_HI;
      if (a < ACC_LO) a = ACC_LO;
    end
    sh = a >>> (DW - 1);
    if (sh > 32767)  sh = 32767;
    if (sh < -32768) sh = -32768;
    return int'(sh);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hist = {};
      for (int k = 0; k < TAPS; k++) begin
        hist.push_back(0);
        coefM[k] = 0;
      end
      busyCnt  = 0;
      expValid = 1'b0;
      expData  = 0;
    end else begin
      expValid = 1'b0;
      if (busyCnt == 0) begin
        if (coefWrEn) coefM[coefAddr] = int'($signed(coefData));
        if (sampleValid) begin
          hist.push_front(int'($signed(sampleData)));
          void'(hist.pop_back());
          busyCnt = TAPS + 1;
        end
      end else begin
        busyCnt = busyCnt - 1;
        if (busyCnt == 0) begin
          expValid = 1'b1;
          expData  = computeOut();
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(sampleReady === (busyCnt == 0), "R6 sampleReady", int'(sampleReady), int'(busyCnt == 0));
      check(resultValid === expValid, "R7 resultValid", int'(resultValid), int'(expValid));
      if (expValid)
        check(int'($signed(resultData)) == expData, "R1 resultData",
              int'($signed(resultData)), expData);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic writeCoef(input int addr, input int val);
    @(negedge clk);
    coefWrEn = 1'b1; coefAddr = AW'(addr); coefData = DW'(val);
    @(negedge clk);
    coefWrEn = 1'b0;
  endtask

  task automatic feed(input int val, input bit poke, input int pokeAddr,
                      input int pokeVal, input int gap, output int res);
    repeat (gap) @(negedge clk);
    do @(negedge clk); while (!sampleReady);
    sampleValid = 1'b1; sampleData = DW'(val);
    @(negedge clk);
    sampleValid = 1'b0;
    if (poke) begin
      // engine is busy now: this write must be dropped (R8)
      coefWrEn = 1'b1; coefAddr = AW'(pokeAddr); coefData = DW'(pokeVal);
      @(negedge clk);
      coefWrEn = 1'b0;
    end
    while (!resultValid) @(negedge clk);
    res = int'($signed(resultData));
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int r;
    repeat (3) @(negedge clk);
    // R10: reset values
    check(sampleReady === 1'b1, "R10 ready after reset", int'(sampleReady), 1);
    check(resultValid === 1'b0, "R10 valid after reset", int'(resultValid), 0);
    check(resultData === '0, "R10 data after reset", int'(resultData), 0);
    rstN = 1'b1;

    // impulse response, coef[k] = (k+1)*1024
    for (int k = 0; k < TAPS; k++) writeCoef(k, (k + 1) * 1024);
    feed(16384, 0, 0, 0, 0, r);
    check(r == 512, "R3 impulse scaling", r, 512);
    for (int k = 1; k < TAPS; k++) begin
      feed(0, 0, 0, 0, 0, r);
      check(r == (k + 1) * 512, "R1 impulse age", r, (k + 1) * 512);
    end
    feed(0, 0, 0, 0, 0, r);
    check(r == 0, "R2 oldest sample dropped", r, 0);

    // truncation toward minus infinity
    for (int k = 0; k < TAPS; k++) writeCoef(k, 0);
    writeCoef(0, 16384);
    feed(-3, 0, 0, 0, 0, r);
    check(r == -2, "R3 negative truncation", r, -2);

    // coefficient write while busy is dropped
    feed(100, 1, 0, 0, 0, r);
    check(r == 50, "R8 result before poke", r, 50);
    feed(200, 0, 0, 0, 2, r);
    check(r == 100, "R8 busy write ignored", r, 100);

    // sampleValid held high while busy must not be taken
    do @(negedge clk); while (!sampleReady);
    sampleValid = 1'b1; sampleData = DW'(40);
    @(negedge clk);
    sampleData = DW'(777);
    repeat (3) begin
      check(sampleReady === 1'b0, "R6 busy ready low", int'(sampleReady), 0);
      @(negedge clk);
    end
    sampleValid = 1'b0;
    while (!resultValid) @(negedge clk);
    check(int'($signed(resultData)) == 20, "R6 busy valid ignored",
          int'($signed(resultData)), 20);

    // output clamping both ways
    for (int k = 0; k < TAPS; k++) writeCoef(k, 32767);
    for (int k = 0; k < TAPS; k++) feed(32767, 0, 0, 0, 0, r);
    check(r == 32767, "R4 positive clamp", r, 32767);
    for (int k = 0; k < TAPS; k++) feed(-32768, 0, 0, 0, 0, r);
    check(r == -32768, "R4 negative clamp", r, -32768);

    // fresh sum each output
    for (int k = 0; k < TAPS; k++) feed(0, 0, 0, 0, 0, r);
    check(r == 0, "R5 accumulator cleared", r, 0);

    // accumulator saturation is visible in the result
    for (int k = 0; k < TAPS; k++) writeCoef(k, (k < 5) ? -32768 : 0);
    for (int k = 0; k < 3; k++) feed(0, 0, 0, 0, 0, r);
    feed(32767, 0, 0, 0, 0, r);
    feed(32767, 0, 0, 0, 0, r);
    for (int k = 0; k < 3; k++) feed(-32768, 0, 0, 0, 0, r);
    check(r == 1, "R9 accumulator saturates", r, 1);

    // random stream, checked by the model
    for (int k = 0; k < TAPS; k++) writeCoef(k, int'($urandom_range(65535)) - 32768);
    for (int n = 0; n < 30; n++)
      feed(int'($urandom_range(65535)) - 32768, 0, 0, 0, int'($urandom_range(3)), r);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

endmodule